// File: doc/BRIEF.md
# Sidetone digital mix attenuator

This block folds an attenuated copy of the captured ADC sample into the stream of samples headed for the DAC, so that a listener hears the capture input alongside the playback material. Both stereo channels are processed together, once per sample period, when the sample strobe is high. The output is a registered pair of 16-bit signed DAC samples.

A one-byte control register holds a mix enable and a 6-bit attenuation code. The code sets the gain in 1.5 dB steps from unity down to -94.5 dB. The gain comes from a computed table and a multiply, and the sum saturates. The block also covers two faults. A capture overrun reuses the last good ADC sample. A playback underrun replaces the playback term with zero. The mix itself runs whether or not playback is enabled.

Top module: `sidetone_mixer`

## Requirements
- R1: A write (`reg_we` high at a clock edge) loads `reg_wdata` into the control register, with bit 0 as the mix enable and bits 7:2 as the attenuation code. Bit 1 is reserved and always stored and read as 0. `reg_rdata` returns the stored value one clock after the write.
- R2: After reset the control register reads 0x00, both DAC outputs are 0 and the held ADC samples are 0.
- R3: The DAC outputs change only at a clock edge where `sample_stb` is high. At every other edge they hold their value.
- R4: With the enable bit at 0, each DAC output becomes that channel's playback term and the ADC input has no effect.
- R5: With the enable bit at 1, each output becomes playback term + floor(adc_term * g / 32768), where g = round(32768 * 10^(-1.5*code/20)). Code 0 gives g = 32768, which is exact unity.
- R6: The playback term is the playback input, whether `play_en` is high or low. `play_en` only decides whether an underrun is honoured, and mixing goes on with playback off.
- R7: When `cap_en` and `cap_ovr` are both high on a strobe, the ADC term is the ADC term of the latest earlier strobe without that condition, and the ADC inputs are ignored. When `cap_en` is low, `cap_ovr` is ignored.
- R8: When `play_en` and `play_unr` are both high on a strobe, the playback term is 0. `play_unr` is ignored when `play_en` is low.
- R9: The sum saturates to the range -32768 to 32767.
- R10: Left and right are computed independently, with the same control settings, on the same strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control write data |
| reg_rdata | output | 8 | Control register read back |
| sample_stb | input | 1 | One-clock sample period strobe |
| cap_en | input | 1 | Capture enabled |
| cap_ovr | input | 1 | Capture overrun flag |
| adc_l | input | 16 | Left captured sample, signed |
| adc_r | input | 16 | Right captured sample, signed |
| play_en | input | 1 | Playback enabled |
| play_unr | input | 1 | Playback underrun flag |
| play_l | input | 16 | Left playback sample, signed |
| play_r | input | 16 | Right playback sample, signed |
| dac_l | output | 16 | Left mixed DAC sample, signed |
| dac_r | output | 16 | Right mixed DAC sample, signed |

## Verification
The assertions assume that `sample_stb` is a single-cycle pulse. They also assume that the control register is not written in the same cycle as a strobe, because the mute and unity checks read the enable and code from `reg_rdata` at the strobe edge. The stimulus always writes the register at least one clock before each strobe and never overlaps the two. It also holds the flag and sample inputs steady between the write and the strobe.

// File: rtl/sidetone_mixer.sv
module sidetone_mixer #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          sample_stb,
  input  logic          cap_en,
  input  logic          cap_ovr,
  input  logic [DW-1:0] adc_l,
  input  logic [DW-1:0] adc_r,
  input  logic          play_en,
  input  logic          play_unr,
  input  logic [DW-1:0] play_l,
  input  logic [DW-1:0] play_r,
  output logic [DW-1:0] dac_l,
  output logic [DW-1:0] dac_r
);
  localparam int NCODE = 1 << AW;

  logic          mix_on;
  logic [AW-1:0] att;
  logic [DW-1:0] gtab [NCODE];
  logic [DW-1:0] gain;
  logic [DW-1:0] adc_in  [2];
  logic [DW-1:0] play_in [2];
  logic [DW-1:0] held    [2];
  logic [DW-1:0] mixed   [2];
  logic [DW-1:0] dac_q   [2];
  logic          use_held, zero_play;

  genvar k;
  for (k = 0; k < NCODE; k++) begin : g_gain
    localparam real GR = (2.0 ** (DW - 1)) * (10.0 ** (-0.075 * k));
    assign gtab[k] = DW'($rtoi(GR + 0.5));
  end

  assign gain      = gtab[att];
  assign use_held  = cap_en & cap_ovr;
  assign zero_play = play_en & play_unr;
  assign adc_in[0]  = adc_l;
  assign adc_in[1]  = adc_r;
  assign play_in[0] = play_l;
  assign play_in[1] = play_r;
  assign reg_rdata  = {att, 1'b0, mix_on};
  assign dac_l = dac_q[0];
  assign dac_r = dac_q[1];

  function automatic logic [DW-1:0] mix1(input logic [DW-1:0] pb, input logic [DW-1:0] ad,
                                         input logic [DW-1:0] g, input logic on);
    logic signed [2*DW:0] p;
    logic signed [DW:0]   s;
    p = $signed(ad) * $signed({1'b0, g});
    p = p >>> (DW - 1);
    s = $signed({pb[DW-1], pb}) + $signed(p[DW:0]);
    if (!on)                 return pb;
    else if (s[DW] == s[DW-1]) return s[DW-1:0];
    else if (s[DW])          return {1'b1, {(DW-1){1'b0}}};
    else                     return {1'b0, {(DW-1){1'b1}}};
  endfunction

  genvar c;
  for (c = 0; c < 2; c++) begin : g_ch
    logic [DW-1:0] a_term, p_term;
    assign a_term   = use_held ? held[c] : adc_in[c];
    assign p_term   = zero_play ? '0 : play_in[c];
    assign mixed[c] = mix1(p_term, a_term, gain, mix_on);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held[c]  <= '0;
        dac_q[c] <= '0;
      end else if (sample_stb) begin
        held[c]  <= a_term;
        dac_q[c] <= mixed[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mix_on <= 1'b0;
      att    <= '0;
    end else if (reg_we) begin
      mix_on <= reg_wdata[0];
      att    <= reg_wdata[7:2];
    end
  end
endmodule

module sidetone_mixer_chk #(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [7:0]    reg_wdata,
  input logic [7:0]    reg_rdata,
  input logic          sample_stb,
  input logic          cap_en,
  input logic          cap_ovr,
  input logic [DW-1:0] adc_l,
  input logic [DW-1:0] adc_r,
  input logic          play_en,
  input logic          play_unr,
  input logic [DW-1:0] play_l,
  input logic [DW-1:0] play_r,
  input logic [DW-1:0] dac_l,
  input logic [DW-1:0] dac_r
);
  a_r1_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_rdata == ($past(reg_wdata) & 8'hFD));

  a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[1] == 1'b0);

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(dac_l) && $stable(dac_r));

  a_r4_mute: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !reg_rdata[0]) |=>
      dac_l == (($past(play_en) && $past(play_unr)) ? '0 : $past(play_l)) &&
      dac_r == (($past(play_en) && $past(play_unr)) ? '0 : $past(play_r)));

  a_r5_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && reg_rdata == 8'h01 && play_en && play_unr && !cap_en) |=>
      dac_l == $past(adc_l) && dac_r == $past(adc_r));
endmodule

bind sidetone_mixer sidetone_mixer_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sidetone_mixer_tb.sv
`timescale 1ns/1ps
module sidetone_mixer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        sample_stb = 1'b0;
  logic        cap_en = 1'b0, cap_ovr = 1'b0, play_en = 1'b0, play_unr = 1'b0;
  logic [15:0] adc_l = '0, adc_r = '0, play_l = '0, play_r = '0;
  logic [15:0] dac_l, dac_r;

  int n_chk = 0, n_fail = 0;
  logic [15:0] h_l = '0, h_r = '0;

  always #4 clk = ~clk;

  sidetone_mixer u_dut (.*);

  // {ctrl, pen, punr, cen, covr, adc_l, adc_r, play_l, play_r}
  localparam int NV = 12;
  localparam logic [75:0] VEC [NV] = '{
    {8'h00, 4'b0000, 16'h1000, 16'h2000, 16'h0100, 16'hFFFB}, // R4 mute
    {8'h01, 4'b0000, 16'h1000, 16'hE000, 16'h0100, 16'h0200}, // R5 unity
    {8'h05, 4'b0000, 16'h4000, 16'hC000, 16'h0000, 16'h0010}, // R5 code1
    {8'h51, 4'b0000, 16'h7FFF, 16'h8000, 16'h0003, 16'hFFFD}, // R5 code20
    {8'hFD, 4'b0000, 16'h7FFF, 16'h8000, 16'h1234, 16'hEDCC}, // R5 code63
    {8'h01, 4'b0000, 16'h7000, 16'h9000, 16'h7000, 16'h9000}, // R9 saturate
    {8'h01, 4'b0011, 16'h0001, 16'h0002, 16'h0000, 16'h0000}, // R7 hold
    {8'h03, 4'b0001, 16'h0044, 16'h0055, 16'h0000, 16'h0000}, // R7 ovr ignored
    {8'h01, 4'b1100, 16'h0100, 16'h0200, 16'h4000, 16'h4000}, // R8 underrun
    {8'h01, 4'b0100, 16'h0100, 16'h0200, 16'h4000, 16'h4000}, // R8 ignored
    {8'h09, 4'b0000, 16'h2000, 16'hE000, 16'h0500, 16'hFB00}, // R6 play off
    {8'h0D, 4'b1111, 16'h5555, 16'h6666, 16'h1111, 16'h2222}  // R7 R8 both
  };

  function automatic logic [15:0] model(input logic [7:0] ctrl, input logic [15:0] pb,
                                        input logic [15:0] ad);
    real g;
    longint t, s;
    if (!ctrl[0]) return pb;
    g = 32768.0 * (10.0 ** (-1.5 * real'(ctrl[7:2]) / 20.0));
    t = longint'($signed(ad)) * longint'($rtoi(g + 0.5));
    t = t >>> 15;
    s = longint'($signed(pb)) + t;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return 16'(s);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic strobe;
    @(negedge clk); sample_stb = 1'b1;
    @(negedge clk); sample_stb = 1'b0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] el, er, al, ar, pl, pr, keep_l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 ctrl", {8'h00, reg_rdata}, 16'h0000);
    check("R2 dac_l", dac_l, 16'h0000);
    check("R2 dac_r", dac_r, 16'h0000);

    wr(8'hFF);
    check("R1 reserved", {8'h00, reg_rdata}, 16'h00FD);
    // R2: held sample is 0 after reset; overrun at unity with zero playback
    wr(8'h01);
    cap_en = 1; cap_ovr = 1; adc_l = 16'h1111; adc_r = 16'h2222;
    strobe();
    check("R2 held l", dac_l, 16'h0000);
    check("R2 held r", dac_r, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] v;
      v = VEC[i];
      wr(v[75:68]);
      check("R1 rdata", {8'h00, reg_rdata}, {8'h00, v[75:68] & 8'hFD});
      {play_en, play_unr, cap_en, cap_ovr} = v[67:64];
      {adc_l, adc_r, play_l, play_r} = v[63:0];
      if (cap_en && cap_ovr) begin al = h_l; ar = h_r; end
      else begin al = adc_l; ar = adc_r; end
      h_l = al; h_r = ar;
      if (play_en && play_unr) begin pl = 0; pr = 0; end
      else begin pl = play_l; pr = play_r; end
      el = model(v[75:68], pl, al);
      er = model(v[75:68], pr, ar);
      strobe();
      check("R5 R10 vector left", dac_l, el);
      check("R5 R10 vector right", dac_r, er);
    end

    // R3: no strobe, outputs held while inputs move
    keep_l = dac_l;
    adc_l = 16'h7777; play_l = 16'h0001; cap_en = 0; play_en = 0;
    repeat (4) @(negedge clk);
    check("R3 hold", dac_l, keep_l);

    // R2: reset mid-run
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R2 rerst dac", dac_l, 16'h0000);
    check("R2 rerst ctrl", {8'h00, reg_rdata}, 16'h0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule